// File: doc/BRIEF.md
# Bus Cycle Sequencer with DRAM Refresh Slot

This block runs the external bus of an 8-bit processor whose address and data buses are separate. The instruction side hands it one machine cycle at a time through a valid/ready request port. Each request carries a cycle kind, an address and, for writes, a data byte. The sequencer drives the active-low strobes that mark the cycle type on the bus: first-cycle, memory request, I/O request, read, write and refresh. It inserts the automatic wait states that slow devices need and stretches a cycle while the external wait pin is low. Each read cycle ends with a one-cycle response that carries the captured byte.

The cycle type is encoded by strobe combinations. First-cycle with memory request marks an opcode fetch. First-cycle with I/O request marks an interrupt acknowledge. Refresh with memory request marks a refresh slot. Every opcode fetch is followed by one refresh slot. In that slot the address bus carries a 7-bit refresh counter in its low bits and the interrupt-vector byte in its upper byte. An external master can take the bus with a bus-request pin. While it holds the bus, every bus output is released.

Back-pressure rules: `req_ready` is high only while the sequencer is idle and no bus request is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is a one-cycle pulse and cannot be stalled, so the consumer must take it when it appears.

Top module: `bus_cycle_seq`

## Requirements
- R1: Kind code 0 is an opcode fetch. It asserts `m1_n`, `mreq_n` and `rd_n` low, keeps `iorq_n`, `wr_n` and `rfsh_n` high, and lasts 3 strobe cycles plus any external wait cycles.
- R2: Kind code 1 is a memory read, which asserts `mreq_n` and `rd_n`. Kind code 2 is a memory write, which asserts `mreq_n` and `wr_n` and drives `req_wdata` on `bus_dout` with `data_oe` high. Both last 3 strobe cycles plus any external wait cycles. Codes 6 and 7 behave as a memory read.
- R3: Kind code 3 is an I/O read, which asserts `iorq_n` and `rd_n`. Kind code 4 is an I/O write, which asserts `iorq_n` and `wr_n` and drives the write byte. Each I/O cycle gets one automatic wait state, so it lasts 4 strobe cycles plus any external wait cycles.
- R4: Kind code 5 is an interrupt acknowledge. It asserts `m1_n` and `iorq_n`, keeps `rd_n` and `wr_n` high, gets two automatic wait states (5 strobe cycles plus any external wait cycles), and returns the vector byte read from `bus_din`.
- R5: Right after every opcode fetch comes exactly one refresh cycle. In it `rfsh_n` and `mreq_n` are low, the other strobes are high, and `bus_addr` = {`int_vec`, 1'b0, refresh counter}.
- R6: The 7-bit refresh counter is 0 after reset. It increments after each refresh cycle and wraps from 127 to 0. Address bit 7 stays 0 during refresh.
- R7: `wait_n` is sampled on the clock edge that ends the first cycle after the automatic waits. Each low sample repeats that cycle once. Samples taken during the first cycle and during automatic waits are ignored.
- R8: `req_ready` is high only when the sequencer is idle and `busreq_n` is high. `rsp_valid` pulses high for one cycle right after the last strobe cycle. For read kinds (0, 1, 3, 5 and 6/7), `rsp_rdata` is then the `bus_din` value of the last strobe cycle.
- R9: If `busreq_n` is low while the sequencer is idle, `busack_n` goes low on the next cycle. While `busack_n` is low, `bus_oe` and `data_oe` are low, all strobes are high and no request is accepted. A bus request raised during a cycle is granted only after that cycle, and its refresh slot, have finished.
- R10: After reset all strobes are high, `bus_oe` is high, `data_oe` is low, `busack_n` is high, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Cycle request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_kind | input | 3 | Cycle kind code (see R1 to R4) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 8 | Captured read byte |
| int_vec | input | 8 | Interrupt-vector byte shown during refresh |
| bus_addr | output | 16 | Address bus value |
| bus_dout | output | 8 | Data bus value to drive |
| bus_din | input | 8 | Data bus value read back |
| bus_oe | output | 1 | Enable for address and strobe drivers |
| data_oe | output | 1 | Enable for data drivers |
| m1_n | output | 1 | First machine cycle strobe |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| rfsh_n | output | 1 | Refresh strobe |
| wait_n | input | 1 | External wait, active low |
| busreq_n | input | 1 | External bus request, active low |
| busack_n | output | 1 | Bus grant, active low |

## Verification
A wrong automatic-wait count or a lost wait sample changes how many cycles the strobes stay active. That shows on the very cycle the strobes should have risen or stayed low, and the response pulse moves with it. A refresh counter that skips or does not wrap shows up on `bus_addr` at the next refresh slot, which comes at most one opcode fetch later. A wrong strobe decode, or a grant issued too early, is visible on the strobe pins or on `busack_n` in the same cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_MRD   = 3'd1;
  localparam logic [2:0] K_MWR   = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;
  localparam logic [2:0] K_IACK  = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_AW, S_T2, S_T3, S_RF, S_GNT
  } seq_state_e;

  typedef enum logic [1:0] { PH_OFF, PH_XFER, PH_RFSH } phase_e;

  typedef struct packed {
    logic m1_n;
    logic mreq_n;
    logic iorq_n;
    logic rd_n;
    logic wr_n;
    logic rfsh_n;
  } strobes_t;

  function automatic logic kind_is_write(logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction
endpackage

// File: rtl/bcs_strobe_dec.sv
module bcs_strobe_dec
  import bcs_pkg::*;
(
  input  phase_e     phase,
  input  logic [2:0] kind,
  output strobes_t   strb
);
  always_comb begin
    strb = '{default: 1'b1};
    if (phase == PH_RFSH) begin
      strb.mreq_n = 1'b0;
      strb.rfsh_n = 1'b0;
    end else if (phase == PH_XFER) begin
      unique case (kind)
        K_FETCH: begin strb.m1_n = 1'b0; strb.mreq_n = 1'b0; strb.rd_n = 1'b0; end
        K_MWR:   begin strb.mreq_n = 1'b0; strb.wr_n = 1'b0; end
        K_IORD:  begin strb.iorq_n = 1'b0; strb.rd_n = 1'b0; end
        K_IOWR:  begin strb.iorq_n = 1'b0; strb.wr_n = 1'b0; end
        K_IACK:  begin strb.m1_n = 1'b0; strb.iorq_n = 1'b0; end
        default: begin strb.mreq_n = 1'b0; strb.rd_n = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/bcs_wait_ctr.sv
module bcs_wait_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero,
  output logic         is_one
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (dec)   cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == W'(1));

  // R3
  auto_wait_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !is_zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/bcs_refresh_ctr.sv
module bcs_refresh_ctr #(
  parameter int RCW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  output logic [RCW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R6
  refresh_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt == $past(cnt) + 1'b1));
  // R6
  refresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int RCW        = 7,
  parameter int IO_WAITS   = 1,
  parameter int IACK_WAITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [AW-RCW-2:0] int_vec,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  input  logic [DW-1:0]     bus_din,
  output logic              bus_oe,
  output logic              data_oe,
  output logic              m1_n,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rfsh_n,
  input  logic              wait_n,
  input  logic              busreq_n,
  output logic              busack_n
);
  localparam int MAXW = (IO_WAITS > IACK_WAITS) ? IO_WAITS : IACK_WAITS;
  localparam int WCW  = (MAXW < 1) ? 1 : $clog2(MAXW + 1);

  seq_state_e     st, st_nx;
  logic [2:0]     kind_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [RCW-1:0] rcnt;
  logic [WCW-1:0] auto_val;
  logic           accept, w_zero, w_one, in_xfer;
  phase_e         phase;
  strobes_t       strb;

  assign req_ready = (st == S_IDLE) && busreq_n;
  assign accept    = req_valid && req_ready;
  assign in_xfer   = (st == S_T1) || (st == S_AW) || (st == S_T2) || (st == S_T3);

  always_comb begin
    if (req_kind == K_IACK)                          auto_val = WCW'(IACK_WAITS);
    else if (req_kind == K_IORD || req_kind == K_IOWR) auto_val = WCW'(IO_WAITS);
    else                                             auto_val = '0;
  end

  bcs_wait_ctr #(.W(WCW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(auto_val),
    .dec(st == S_AW), .is_zero(w_zero), .is_one(w_one)
  );

  bcs_refresh_ctr #(.RCW(RCW)) u_rfsh (
    .clk(clk), .rst_n(rst_n), .inc(st == S_RF), .cnt(rcnt)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE: if (!busreq_n) st_nx = S_GNT;
              else if (req_valid) st_nx = S_T1;
      S_T1:   st_nx = w_zero ? S_T2 : S_AW;
      S_AW:   if (w_one) st_nx = S_T2;
      S_T2:   if (wait_n) st_nx = S_T3;
      S_T3:   st_nx = (kind_q == K_FETCH) ? S_RF : S_IDLE;
      S_RF:   st_nx = S_IDLE;
      S_GNT:  if (busreq_n) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind_q    <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= st_nx;
      rsp_valid <= (st == S_T3);
      if (st == S_T3) rsp_rdata <= bus_din;
      if (accept) begin
        kind_q  <= req_kind;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign phase = (st == S_RF) ? PH_RFSH : (in_xfer ? PH_XFER : PH_OFF);

  bcs_strobe_dec u_dec (.phase(phase), .kind(kind_q), .strb(strb));

  assign m1_n     = strb.m1_n;
  assign mreq_n   = strb.mreq_n;
  assign iorq_n   = strb.iorq_n;
  assign rd_n     = strb.rd_n;
  assign wr_n     = strb.wr_n;
  assign rfsh_n   = strb.rfsh_n;
  assign busack_n = (st != S_GNT);
  assign bus_oe   = (st != S_GNT);
  assign data_oe  = in_xfer && kind_is_write(kind_q);
  assign bus_dout = wdata_q;
  assign bus_addr = (st == S_RF) ? {int_vec, 1'b0, rcnt} : addr_q;

  // R1
  fetch_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n && !mreq_n) |-> (!rd_n && wr_n && iorq_n && rfsh_n));
  // R2
  req_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n && !iorq_n));
  // R4
  iack_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n && !iorq_n) |-> (rd_n && wr_n));
  // R5
  refresh_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (!mreq_n && m1_n && rd_n && wr_n && !bus_addr[RCW]));
  // R5
  refresh_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n && !mreq_n && st == S_T3) |=> !rfsh_n);
  // R7
  ext_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2 && !wait_n) |=> (st == S_T2));
  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  grant_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |-> (!bus_oe && !data_oe && mreq_n && iorq_n && rd_n && wr_n && !req_ready));
endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [7:0]  int_vec = '0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout, bus_din = '0;
  logic        bus_oe, data_oe, m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n;
  logic        wait_n = 1'b1, busreq_n = 1'b1, busack_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [6:0] rexp = '0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_strb(input logic [2:0] k);
    case (k)
      3'd0: return 6'b001011;
      3'd2: return 6'b101101;
      3'd3: return 6'b110011;
      3'd4: return 6'b110101;
      3'd5: return 6'b010111;
      default: return 6'b101011;
    endcase
  endfunction

  function automatic int auto_w(input logic [2:0] k);
    if (k == 3'd5) return 2;
    if (k == 3'd3 || k == 3'd4) return 1;
    return 0;
  endfunction

  function automatic string tag(input logic [2:0] k);
    case (k)
      3'd0: return "R1";
      3'd3, 3'd4: return "R3";
      3'd5: return "R4";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [5:0] cur_strb();
    return {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n};
  endfunction

  task automatic run_txn(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                         input logic [7:0] din, input logic [7:0] iv, input int nw, input bit gmid);
    int aw = auto_w(k);
    int kk = 0;
    bit strb_ok = 1, addr_ok = 1, data_ok = 1, rdy_ok = 1, ack_ok = 1;
    logic [5:0] bad_s = '0;
    bit is_rd = !(k == 3'd2 || k == 3'd4);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd; bus_din = din; int_vec = iv;
    chk(req_ready, "R8", {31'd0, req_ready}, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    forever begin
      wait_n = !(kk >= 1 + aw && kk < 1 + aw + nw);
      if (gmid && kk == 0) busreq_n = 0;
      if (!((!mreq_n || !iorq_n) && rfsh_n)) break;
      if (cur_strb() != exp_strb(k)) begin strb_ok = 0; bad_s = cur_strb(); end
      if (bus_addr != a) addr_ok = 0;
      if (!is_rd && !(data_oe && bus_dout == wd)) data_ok = 0;
      if (is_rd && data_oe) data_ok = 0;
      if (req_ready) rdy_ok = 0;
      if (!busack_n) ack_ok = 0;
      kk++;
      @(posedge clk);
      @(negedge clk);
    end
    wait_n = 1;
    chk(strb_ok, tag(k), {26'd0, bad_s}, {26'd0, exp_strb(k)});
    chk(addr_ok, tag(k), 0, 1);
    chk(data_ok, tag(k), 0, 1);
    chk(rdy_ok, "R8", 0, 1);
    if (gmid) chk(ack_ok, "R9", 0, 1);
    if (nw > 0) chk(kk == 3 + aw + nw, "R7", kk, 3 + aw + nw);
    else        chk(kk == 3 + aw, tag(k), kk, 3 + aw);
    chk(rsp_valid, "R8", {31'd0, rsp_valid}, 1);
    if (is_rd) chk(rsp_rdata == din, "R8", rsp_rdata, din);
    if (k == 3'd0) begin
      chk(cur_strb() == 6'b101110, "R5", cur_strb(), 6'b101110);
      chk(bus_addr == {iv, 1'b0, rexp}, "R6", bus_addr, {iv, 1'b0, rexp});
      if (gmid) chk(busack_n, "R9", busack_n, 1);
      rexp = rexp + 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(!rsp_valid && rfsh_n, "R5", {rsp_valid, rfsh_n}, 2'b01);
    end
    if (gmid) begin
      @(posedge clk);
      @(negedge clk);
      chk(!busack_n && !bus_oe, "R9", {busack_n, bus_oe}, 0);
      busreq_n = 1;
      @(posedge clk);
      @(negedge clk);
      chk(busack_n, "R9", busack_n, 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(cur_strb() == 6'h3f && bus_oe && !data_oe && busack_n && req_ready && !rsp_valid,
        "R10", {cur_strb(), bus_oe, data_oe, busack_n, req_ready, rsp_valid},
        {6'h3f, 5'b10110});

    // directed: every kind, no external waits
    for (int k = 0; k < 6; k++) run_txn(3'(k), 16'h1234 + 16'(k), 8'hA5, 8'h5A + 8'(k), 8'hC3, 0, 0);
    // kind 7 behaves as memory read (R2)
    run_txn(3'd7, 16'hBEEF, 8'h00, 8'h77, 8'h11, 0, 0);
    // external waits on fetch and interrupt acknowledge (R7)
    run_txn(3'd0, 16'h0100, 8'h00, 8'h3C, 8'h22, 2, 0);
    run_txn(3'd5, 16'h0200, 8'h00, 8'hFF, 8'h33, 3, 0);

    // R9 grant from idle, request held off
    @(negedge clk);
    busreq_n = 0; req_valid = 1; req_kind = 3'd1;
    @(posedge clk);
    @(negedge clk);
    chk(!busack_n && !bus_oe && !data_oe && cur_strb() == 6'h3f && !req_ready, "R9",
        {busack_n, bus_oe, data_oe, req_ready}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busack_n && mreq_n, "R9", {busack_n, mreq_n}, 2'b01);
    req_valid = 0; busreq_n = 1;
    @(posedge clk);
    @(negedge clk);
    chk(busack_n && bus_oe && req_ready, "R9", {busack_n, bus_oe, req_ready}, 3'b111);

    // R9 request raised mid-cycle
    run_txn(3'd1, 16'h4444, 8'h00, 8'h44, 8'h00, 1, 1);
    run_txn(3'd0, 16'h5555, 8'h00, 8'h55, 8'h9A, 0, 1);

    // random mix; many fetches cover the R6 wrap
    for (int i = 0; i < 500; i++) begin
      logic [2:0] k = 3'($urandom % 6);
      if ($urandom % 3 == 0) k = 3'd0;
      run_txn(k, 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              ($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0, ($urandom % 10) == 0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule